// File: doc/BRIEF.md
# DRAM Request Scheduler

This block sits between the request side of a DRAM controller and its command back-end. Requests arrive already split into bank, row and column together with a read/write flag. They wait in a small queue. Each cycle the block offers exactly one of them to the back-end through a valid/ready handshake.

The choice is made by successive filters over the pending entries:

1. Entries whose bank currently holds their target row open win first.
2. Among the survivors, entries that keep the data bus in the direction of the last issued request win next.
3. Reads then beat writes.
4. The oldest remaining entry is chosen.

The block keeps a table of the open row of each bank. The back-end updates this table by reporting each row activation and each bank close. The block also remembers the direction of the last grant. It forgets that direction once the queue has been empty for a cycle, because the bus is then idle.

An entry can be passed over by younger entries only a limited number of times. After that many grants have gone to other entries while it was the oldest, it is issued regardless of its rank.

Top module: `dram_req_sched`

## Requirements
- R1: After reset `req_ready` is 1, `gnt_valid` is 0, every bank is recorded as closed and no last direction is held.
- R2: A request is stored on a cycle with `req_valid` and `req_ready` both 1. `req_ready` is 0 exactly while QDEPTH (8) entries are held, and a request presented then is dropped. An entry granted in a cycle frees its slot, so `req_ready` is 1 in the following cycle.
- R3: Any entry whose bank has its target row open is granted before every entry that misses, whatever their direction, type or age. `gnt_hit` is 1 exactly when the granted entry is such a hit.
- R4: Among entries of equal hit status, while a last direction is held, entries with the same `wr` value as the last granted entry win.
- R5: When no last direction is held, reads (`req_wr`=0) win over writes among entries of equal hit status. The last direction is dropped after any cycle in which the queue is empty.
- R6: Entries still tied after R3 to R5 are granted oldest first, age being order of acceptance.
- R7: When STARVE_LIM (16) grants have gone to other entries while one entry stayed the oldest, the next grant goes to that oldest entry regardless of rank.
- R8: The open-row table is kept per bank. `fb_act` records `fb_row` as open in bank `fb_bank`, `fb_pre` closes bank `fb_bank`, and `fb_act` wins if both are 1. Other banks are unaffected, and the change applies to selections from the next cycle.
- R9: `gnt_valid` is 1 whenever the queue holds an entry. `gnt_wr`, `gnt_bank`, `gnt_row` and `gnt_col` carry the fields of the selected entry unchanged.
- R10: While `gnt_ready` is 0 no entry leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Queue has a free slot |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Target row |
| req_col | input | 10 | Target column |
| gnt_valid | output | 1 | A selected request is offered |
| gnt_ready | input | 1 | Back-end takes the offered request |
| gnt_wr | output | 1 | Direction of offered request |
| gnt_bank | output | 3 | Bank of offered request |
| gnt_row | output | 14 | Row of offered request |
| gnt_col | output | 10 | Column of offered request |
| gnt_hit | output | 1 | Offered request targets an open row |
| fb_act | input | 1 | Back-end opened row `fb_row` in bank `fb_bank` |
| fb_pre | input | 1 | Back-end closed bank `fb_bank` |
| fb_bank | input | 3 | Bank of the feedback event |
| fb_row | input | 14 | Row of an activation event |

## Verification
The situation hardest to reach from the ports is the starvation override. An old miss must remain queued while sixteen younger entries overtake it one grant at a time. The stimulus opens a row in one bank, parks a miss to another bank, and then pushes a fresh hit to the open row in the same cycle as each grant, so that a hit is always available to bypass the old entry. The grant after the sixteenth bypass must be the old miss. The drop of the last direction after an idle cycle is also reached only through ordering. A write that hits sets the direction, and a second pair of entries follows only after the queue has drained.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

   // per-entry ranking flags, highest weight first
   typedef struct packed {
      logic hit;
      logic same_dir;
      logic is_rd;
   } rank_t;

   // index of the lowest set bit, 0 when none is set
   function automatic int unsigned lsb_index(input logic [63:0] v);
      int unsigned r;
      r = 0;
      for (int i = 63; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/dsch_open_rows.sv
module dsch_open_rows #(
   parameter int NBANK = 8,
   parameter int ROW_W = 14,
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic              pre_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  row_i,
   output logic [NBANK-1:0]  open_o,
   output logic [ROW_W-1:0]  row_o [NBANK]
);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel;
      assign sel = (bank_i == BANK_W'(b));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_o[b] <= 1'b0;
            row_o[b]  <= '0;
         end else if (sel && act_i) begin
            open_o[b] <= 1'b1;
            row_o[b]  <= row_i;
         end else if (sel && pre_i) begin
            open_o[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dsch_queue.sv
module dsch_queue
   import dram_sched_pkg::*;
#(
   parameter int QDEPTH = 8,
   parameter int NBANK  = 8,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 10,
   localparam int BANK_W = $clog2(NBANK),
   localparam int IDX_W  = $clog2(QDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put_i,
   input  logic              wr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              take_i,
   input  logic [IDX_W-1:0]  take_idx_i,
   output logic              has_free_o,
   output logic [QDEPTH-1:0] vld_o,
   output logic [QDEPTH-1:0] wr_o,
   output logic [BANK_W-1:0] bank_o [QDEPTH],
   output logic [ROW_W-1:0]  row_o  [QDEPTH],
   output logic [COL_W-1:0]  col_o  [QDEPTH],
   // older_o[i][j] set: entry i was accepted before entry j
   output logic [QDEPTH-1:0] older_o [QDEPTH]
);

   logic [QDEPTH-1:0] free_vec;
   logic [IDX_W-1:0]  put_idx;
   logic [QDEPTH-1:0] take_oh;

   assign free_vec   = ~vld_o;
   assign has_free_o = |free_vec;
   assign put_idx    = IDX_W'(lsb_index(64'(free_vec)));

   for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
      logic put_here;
      assign take_oh[i] = take_i && (take_idx_i == IDX_W'(i));
      assign put_here   = put_i && (put_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_o[i] <= 1'b0;
         end else if (put_here) begin
            vld_o[i] <= 1'b1;
         end else if (take_oh[i]) begin
            vld_o[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (put_here) begin
            wr_o[i]   <= wr_i;
            bank_o[i] <= bank_i;
            row_o[i]  <= row_i;
            col_o[i]  <= col_i;
         end
      end

      for (genvar j = 0; j < QDEPTH; j++) begin : g_age
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               older_o[i][j] <= 1'b0;
            end else if (put_i && (put_idx == IDX_W'(j)) && (i != j)) begin
               // existing entries become older than the new one in slot j
               older_o[i][j] <= vld_o[i] && !take_oh[i];
            end else if (put_here) begin
               older_o[i][j] <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/dsch_pick.sv
module dsch_pick
   import dram_sched_pkg::*;
#(
   parameter int QDEPTH = 8,
   localparam int IDX_W = $clog2(QDEPTH)
) (
   input  logic [QDEPTH-1:0] vld_i,
   input  logic [QDEPTH-1:0] hit_i,
   input  logic [QDEPTH-1:0] wr_i,
   input  logic              dir_known_i,
   input  logic              last_wr_i,
   input  logic [QDEPTH-1:0] older_i [QDEPTH],
   input  logic              force_old_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              is_oldest_o
);

   rank_t             rank [QDEPTH];
   logic [QDEPTH-1:0] m_hit, m_dir, m_rd, m_fin;
   logic [QDEPTH-1:0] oldest_all, oldest_fin;

   for (genvar i = 0; i < QDEPTH; i++) begin : g_rank
      assign rank[i].hit      = hit_i[i];
      assign rank[i].same_dir = dir_known_i && (wr_i[i] == last_wr_i);
      assign rank[i].is_rd    = !wr_i[i];
   end

   always_comb begin
      logic [QDEPTH-1:0] f;
      f = '0;
      for (int i = 0; i < QDEPTH; i++) f[i] = rank[i].hit;
      m_hit = |(vld_i & f) ? (vld_i & f) : vld_i;
      for (int i = 0; i < QDEPTH; i++) f[i] = rank[i].same_dir;
      m_dir = |(m_hit & f) ? (m_hit & f) : m_hit;
      for (int i = 0; i < QDEPTH; i++) f[i] = rank[i].is_rd;
      m_rd  = |(m_dir & f) ? (m_dir & f) : m_dir;
      m_fin = force_old_i ? vld_i : m_rd;
   end

   // an entry is oldest in a set when no other member of the set precedes it
   always_comb begin
      for (int i = 0; i < QDEPTH; i++) begin
         logic prec_all, prec_fin;
         prec_all = 1'b0;
         prec_fin = 1'b0;
         for (int j = 0; j < QDEPTH; j++) begin
            if (j != i) begin
               prec_all |= vld_i[j] & older_i[j][i];
               prec_fin |= m_fin[j] & older_i[j][i];
            end
         end
         oldest_all[i] = vld_i[i] & !prec_all;
         oldest_fin[i] = m_fin[i] & !prec_fin;
      end
   end

   assign any_o       = |vld_i;
   assign idx_o       = IDX_W'(lsb_index(64'(oldest_fin)));
   assign is_oldest_o = |(oldest_fin & oldest_all);

endmodule

// File: rtl/dsch_starve.sv
module dsch_starve #(
   parameter int STARVE_LIM = 16,
   localparam int CNT_W = $clog2(STARVE_LIM + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic fire_oldest_i,
   output logic force_o
);

   if (STARVE_LIM == 0) begin : g_off
      assign force_o = 1'b0;
   end else begin : g_on
      logic [CNT_W-1:0] bypass_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bypass_cnt <= '0;
         end else if (fire_i) begin
            if (fire_oldest_i)
               bypass_cnt <= '0;
            else if (bypass_cnt < CNT_W'(STARVE_LIM))
               bypass_cnt <= bypass_cnt + 1'b1;
         end
      end
      assign force_o = (bypass_cnt >= CNT_W'(STARVE_LIM));
   end

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
   import dram_sched_pkg::*;
#(
   parameter int QDEPTH     = 8,
   parameter int NBANK      = 8,
   parameter int ROW_W      = 14,
   parameter int COL_W      = 10,
   parameter int STARVE_LIM = 16,
   localparam int BANK_W = $clog2(NBANK),
   localparam int IDX_W  = $clog2(QDEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_wr,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              gnt_valid,
   input  logic              gnt_ready,
   output logic              gnt_wr,
   output logic [BANK_W-1:0] gnt_bank,
   output logic [ROW_W-1:0]  gnt_row,
   output logic [COL_W-1:0]  gnt_col,
   output logic              gnt_hit,
   input  logic              fb_act,
   input  logic              fb_pre,
   input  logic [BANK_W-1:0] fb_bank,
   input  logic [ROW_W-1:0]  fb_row
);

   if (QDEPTH < 2 || QDEPTH > 64 || (1 << IDX_W) != QDEPTH) begin : g_bad_depth
      $error("QDEPTH must be a power of two between 2 and 64");
   end
   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_bank
      $error("NBANK must be a power of two of at least 2");
   end
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("ROW_W and COL_W must be positive");
   end

   logic [QDEPTH-1:0] q_vld, q_wr, q_hit;
   logic [BANK_W-1:0] q_bank [QDEPTH];
   logic [ROW_W-1:0]  q_row  [QDEPTH];
   logic [COL_W-1:0]  q_col  [QDEPTH];
   logic [QDEPTH-1:0] q_older [QDEPTH];
   logic [NBANK-1:0]  bk_open;
   logic [ROW_W-1:0]  bk_row [NBANK];

   logic             accept, fire, sel_any, sel_oldest, force_old;
   logic [IDX_W-1:0] sel_idx;
   logic             dir_known, last_wr;

   assign accept = req_valid && req_ready;
   assign fire   = gnt_valid && gnt_ready;

   dsch_open_rows #(.NBANK(NBANK), .ROW_W(ROW_W)) u_rows (
      .clk(clk), .rst_n(rst_n),
      .act_i(fb_act), .pre_i(fb_pre), .bank_i(fb_bank), .row_i(fb_row),
      .open_o(bk_open), .row_o(bk_row)
   );

   dsch_queue #(.QDEPTH(QDEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .put_i(accept), .wr_i(req_wr), .bank_i(req_bank), .row_i(req_row), .col_i(req_col),
      .take_i(fire), .take_idx_i(sel_idx),
      .has_free_o(req_ready), .vld_o(q_vld), .wr_o(q_wr),
      .bank_o(q_bank), .row_o(q_row), .col_o(q_col), .older_o(q_older)
   );

   for (genvar i = 0; i < QDEPTH; i++) begin : g_hit
      assign q_hit[i] = bk_open[q_bank[i]] && (bk_row[q_bank[i]] == q_row[i]);
   end

   dsch_pick #(.QDEPTH(QDEPTH)) u_pick (
      .vld_i(q_vld), .hit_i(q_hit), .wr_i(q_wr),
      .dir_known_i(dir_known), .last_wr_i(last_wr),
      .older_i(q_older), .force_old_i(force_old),
      .any_o(sel_any), .idx_o(sel_idx), .is_oldest_o(sel_oldest)
   );

   dsch_starve #(.STARVE_LIM(STARVE_LIM)) u_starve (
      .clk(clk), .rst_n(rst_n),
      .fire_i(fire), .fire_oldest_i(sel_oldest), .force_o(force_old)
   );

   // bus direction memory, dropped once the queue sits empty
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_known <= 1'b0;
         last_wr   <= 1'b0;
      end else if (fire) begin
         dir_known <= 1'b1;
         last_wr   <= q_wr[sel_idx];
      end else if (!sel_any) begin
         dir_known <= 1'b0;
      end
   end

   assign gnt_valid = sel_any;
   assign gnt_wr    = q_wr[sel_idx];
   assign gnt_bank  = q_bank[sel_idx];
   assign gnt_row   = q_row[sel_idx];
   assign gnt_col   = q_col[sel_idx];
   assign gnt_hit   = q_hit[sel_idx];

endmodule

// File: rtl/dram_req_sched_chk.sv
module dram_req_sched_chk #(
   parameter int QDEPTH     = 8,
   parameter int NBANK      = 8,
   parameter int ROW_W      = 14,
   parameter int COL_W      = 10,
   parameter int STARVE_LIM = 16,
   localparam int BANK_W = $clog2(NBANK),
   localparam int OCC_W  = $clog2(QDEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_wr,
   input logic [BANK_W-1:0] req_bank,
   input logic [ROW_W-1:0]  req_row,
   input logic [COL_W-1:0]  req_col,
   input logic              gnt_valid,
   input logic              gnt_ready,
   input logic              gnt_wr,
   input logic [BANK_W-1:0] gnt_bank,
   input logic [ROW_W-1:0]  gnt_row,
   input logic [COL_W-1:0]  gnt_col,
   input logic              gnt_hit,
   input logic              fb_act,
   input logic              fb_pre,
   input logic [BANK_W-1:0] fb_bank,
   input logic [ROW_W-1:0]  fb_row
);

   logic [OCC_W-1:0] occ;
   logic [NBANK-1:0] sh_open;
   logic [ROW_W-1:0] sh_row [NBANK];

   always_ff @(posedge clk) begin
      if (!rst_n)
         occ <= '0;
      else
         occ <= occ + OCC_W'(req_valid && req_ready) - OCC_W'(gnt_valid && gnt_ready);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_open <= '0;
         for (int b = 0; b < NBANK; b++) sh_row[b] <= '0;
      end else if (fb_act) begin
         sh_open[fb_bank] <= 1'b1;
         sh_row[fb_bank]  <= fb_row;
      end else if (fb_pre) begin
         sh_open[fb_bank] <= 1'b0;
      end
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (req_ready && !gnt_valid));

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready == (occ < OCC_W'(QDEPTH)));

   // R9
   offer_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid == (occ != '0));

   // R10
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_ready) |=> gnt_valid);

   // R3
   hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> (gnt_hit == (sh_open[gnt_bank] && sh_row[gnt_bank] == gnt_row)));

endmodule

bind dram_req_sched dram_req_sched_chk #(
   .QDEPTH(QDEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W), .STARVE_LIM(STARVE_LIM)
) u_chk (.*);

// File: tb/dram_req_sched_test.sv
module dram_req_sched_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_wr = 1'b0;
   logic [2:0]  req_bank = '0;
   logic [13:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic        gnt_ready = 1'b0;
   logic        fb_act = 1'b0, fb_pre = 1'b0;
   logic [2:0]  fb_bank = '0;
   logic [13:0] fb_row = '0;
   logic        req_ready, gnt_valid, gnt_wr, gnt_hit;
   logic [2:0]  gnt_bank;
   logic [13:0] gnt_row;
   logic [9:0]  gnt_col;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dram_req_sched uut (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic push(input bit wr, input int bank, input int row, input int col);
      @(negedge clk);
      req_valid = 1'b1; req_wr = wr;
      req_bank = 3'(bank); req_row = 14'(row); req_col = 10'(col);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic fb(input bit a, input bit p, input int bank, input int row);
      @(negedge clk);
      fb_act = a; fb_pre = p; fb_bank = 3'(bank); fb_row = 14'(row);
      @(posedge clk); #1;
      fb_act = 1'b0; fb_pre = 1'b0;
   endtask

   // offers are packed as {valid, wr, bank, row, hit}
   task automatic take(input bit wr, input int bank, input int row, input bit hit, input string tag);
      logic [19:0] got, exp;
      @(negedge clk);
      gnt_ready = 1'b1;
      #1;
      got = {gnt_valid, gnt_wr, gnt_bank, gnt_row, gnt_hit};
      exp = {1'b1, wr, 3'(bank), 14'(row), hit};
      chk(got == exp, tag, got, exp);
      @(posedge clk); #1;
      gnt_ready = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
      chk(gnt_valid === 1'b0, "R1 no offer after reset", gnt_valid, 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 8; i++) push(1'b0, 0, 100 + i, i);
      @(negedge clk);
      chk(req_ready === 1'b0, "R2 full blocks requests", req_ready, 0);
      chk(gnt_valid === 1'b1, "R9 offer while held", gnt_valid, 1);
      push(1'b0, 5, 999, 99);  // dropped: queue full
      take(1'b0, 0, 100, 1'b0, "R6 oldest first 0");
      @(negedge clk);
      chk(req_ready === 1'b1, "R2 slot freed by grant", req_ready, 1);
      for (int i = 1; i < 8; i++) take(1'b0, 0, 100 + i, 1'b0, "R6 oldest first");
      @(negedge clk);
      chk(gnt_valid === 1'b0, "R2 request at full was dropped", gnt_valid, 0);
   endtask

   task automatic t_hold();
      push(1'b1, 6, 3, 0);
      idle(3);
      @(negedge clk);
      chk(gnt_valid === 1'b1 && gnt_row == 14'd3, "R10 no removal without ready", gnt_row, 3);
      take(1'b1, 6, 3, 1'b0, "R10 entry kept");
      idle(2);
   endtask

   task automatic t_hit();
      fb(1'b1, 1'b0, 2, 5);
      push(1'b0, 1, 9, 0);
      push(1'b1, 2, 5, 0);
      push(1'b0, 2, 6, 0);
      take(1'b1, 2, 5, 1'b1, "R3 hit beats older reads");
      take(1'b0, 1, 9, 1'b0, "R6 older of two misses");
      take(1'b0, 2, 6, 1'b0, "R3 miss in open bank");
      idle(2);
   endtask

   task automatic t_banks();
      fb(1'b1, 1'b0, 3, 7);   // bank 2 keeps row 5
      push(1'b0, 3, 8, 0);
      push(1'b0, 2, 5, 0);
      push(1'b0, 3, 7, 0);
      take(1'b0, 2, 5, 1'b1, "R8 bank 2 still open");
      take(1'b0, 3, 7, 1'b1, "R8 bank 3 open");
      take(1'b0, 3, 8, 1'b0, "R8 other row misses");
      idle(2);
      fb(1'b0, 1'b1, 2, 0);
      push(1'b0, 6, 0, 0);
      push(1'b0, 2, 5, 0);
      take(1'b0, 6, 0, 1'b0, "R8 closed bank no longer hits");
      take(1'b0, 2, 5, 1'b0, "R8 closed bank entry");
      idle(2);
      fb(1'b1, 1'b1, 6, 0);
      push(1'b0, 1, 1, 0);
      push(1'b0, 6, 0, 0);
      take(1'b0, 6, 0, 1'b1, "R8 activate wins over close");
      take(1'b0, 1, 1, 1'b0, "R8 remaining entry");
      idle(2);
   endtask

   task automatic t_dir();
      fb(1'b1, 1'b0, 4, 1);
      push(1'b1, 4, 1, 0);
      push(1'b0, 4, 2, 0);
      push(1'b1, 4, 3, 0);
      take(1'b1, 4, 1, 1'b1, "R4 hit write sets direction");
      take(1'b1, 4, 3, 1'b0, "R4 write follows write");
      take(1'b0, 4, 2, 1'b0, "R4 read last");
      idle(2);
   endtask

   task automatic t_read();
      push(1'b1, 5, 1, 0);
      push(1'b0, 5, 2, 0);
      take(1'b0, 5, 2, 1'b0, "R5 read beats older write");
      take(1'b1, 5, 1, 1'b0, "R5 write after");
      idle(2);
   endtask

   task automatic t_starve();
      fb(1'b1, 1'b0, 0, 3);
      push(1'b0, 7, 0, 0);
      push(1'b0, 0, 3, 0);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_wr = 1'b0; req_bank = 3'd0; req_row = 14'd3; req_col = 10'(k + 1);
         gnt_ready = 1'b1;
         #1;
         chk(gnt_valid && gnt_bank == 3'd0 && gnt_col == 10'(k), "R7 hit bypasses before limit",
             {gnt_bank, gnt_col}, {3'd0, 10'(k)});
         @(posedge clk); #1;
         req_valid = 1'b0; gnt_ready = 1'b0;
      end
      take(1'b0, 7, 0, 1'b0, "R7 starving entry forced");
      take(1'b0, 0, 3, 1'b1, "R7 last hit drained");
      idle(2);
   endtask

   initial begin
      idle(3);
      #5 rst_n = 1'b1;
      t_reset();
      t_fill();
      t_hold();
      t_hit();
      t_banks();
      t_dir();
      t_read();
      t_starve();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule